// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds a software-managed translation buffer. Software loads two page-descriptor words, an index word and a command word through a narrow register write port. Each command then moves a descriptor between these holding registers and the entry array, or looks one up. The main array is set-associative. The set is picked by the low bits of the virtual page number. Entries are numbered linearly with the ways of one set side by side. A separate small fully associative bank holds large pages. A descriptor with its size bit set is routed to that bank, and the bank answers at linear indices starting at a fixed base above the main array.

Lookup results come back through the index word. A hit returns the linear index of the matching entry. A miss sets an error flag. A lookup that matches more than one entry returns a separate duplicate code. Duplicates are only found at lookup time: a write never checks for them. Some commands also raise a one-cycle pulse that tells the small per-port translation caches to drop their contents.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset, every entry in both banks is invalid, the index word reads 0, busy is low and the invalidate pulse is low.
- R2: Descriptor word 0 layout: bits [7:0] address-space ID, bit 8 global, bit 9 valid, bit 10 large-page size flag, bits [31:12] virtual page number. The set index is the low bits of the virtual page number (bits [15:12] with 16 sets). Descriptor word 1 is stored and returned unchanged. Register select codes: 0 word 0, 1 word 1, 2 index, 3 command.
- R3: Write (code 1) copies both descriptor words into the entry named by the index word and pulses the invalidate output for exactly one cycle. Write-quiet (code 2) does the same copy with no pulse. Read (code 3) loads both descriptor words from the entry named by the index word.
- R4: Probe (code 4) compares the key against every way of the selected set. On a single hit it loads the index word with set × ways + way, with flag bits clear. Index word layout: bits [11:0] entry index, bit 31 miss flag, bit 30 duplicate flag.
- R5: A probe with no matching valid entry loads the index word with 0x8000_0000.
- R6: A probe matching more than one entry loads 0xC000_0000.
- R7: An entry matches only if its address-space ID equals the key's, unless its global bit is set, in which case any ID matches.
- R8: Get-index (code 5) loads the index word with the lowest invalid way of the selected set. If the set is full it returns a round-robin victim, which starts at way 0 after reset and advances each time it is used.
- R9: Insert (code 6) writes descriptor word 0 with its valid bit forced to 1, together with word 1. It overwrites a matching entry if there is one, otherwise it uses the get-index choice. It pulses the invalidate output.
- R10: Delete (code 7) invalidates every entry matching the key and pulses the invalidate output.
- R11: When the key's size bit is set, probe, get-index, insert and delete act on the 16-entry large-page bank. That bank is indexed 0x800 + slot and compares only virtual address bits [31:21]. Write and read reach this bank at those indices.
- R12: Every command keeps busy high for exactly one cycle and delivers its result in the cycle after. Register and command writes made while busy is high are ignored.
- R13: Invalidate (code 8) only pulses the invalidate output. Probe, read and get-index never pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 word 0, 1 word 1, 2 index, 3 command) |
| wr_data | input | 32 | Write data |
| pd0_o | output | 32 | Descriptor word 0 holding register |
| pd1_o | output | 32 | Descriptor word 1 holding register |
| index_o | output | 32 | Index word with miss and duplicate flags |
| busy_o | output | 1 | Command in progress |
| utlb_inv_o | output | 1 | One-cycle invalidate pulse for the small translation caches |

## Verification
The bench builds the block with its defaults: 16 sets, 4 ways, a 16-slot large-page bank based at 0x800, and global matching enabled. With only four ways, four inserts fill one set. That makes the round-robin victim path and the overwrite-on-hit path of insert reachable in a few commands. With 16 sets, the page numbers used in the tests land in known sets, so every expected linear index can be worked out by hand. The large-page bank sits at a base far above the 64 main entries, so a wrong bank choice shows up directly in the returned index.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;
   typedef enum logic [3:0] {
      CMD_NONE     = 4'd0,
      CMD_WRITE    = 4'd1,
      CMD_WRITE_NI = 4'd2,
      CMD_READ     = 4'd3,
      CMD_PROBE    = 4'd4,
      CMD_GETIDX   = 4'd5,
      CMD_INSERT   = 4'd6,
      CMD_DELETE   = 4'd7,
      CMD_UINV     = 4'd8
   } tlbe_cmd_e;

   typedef enum logic [1:0] {
      REG_PD0   = 2'd0,
      REG_PD1   = 2'd1,
      REG_INDEX = 2'd2,
      REG_CMD   = 2'd3
   } tlbe_reg_e;

   localparam int unsigned ASID_W     = 8;
   localparam int unsigned GLOBAL_BIT = 8;
   localparam int unsigned VALID_BIT  = 9;
   localparam int unsigned SIZE_BIT   = 10;
   localparam int unsigned MISS_BIT   = 31;
   localparam int unsigned DUP_BIT    = 30;
endpackage

// File: rtl/tlbe_match.sv
module tlbe_match
   import tlbe_pkg::*;
#(
   parameter int unsigned N         = 4,
   parameter int unsigned TAG_LSB   = 12,
   parameter bit          GLOBAL_EN = 1'b1
) (
   input  logic [N-1:0][31:0] entries_i,
   input  logic [31:0]        key_i,
   output logic [N-1:0]       hit_o
);
   if (TAG_LSB > 31 || TAG_LSB <= ASID_W) begin : g_bad_tag
      $error("tlbe_match: TAG_LSB out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      logic tag_eq, asid_eq, any_asid;
      assign tag_eq  = entries_i[i][31:TAG_LSB] == key_i[31:TAG_LSB];
      assign asid_eq = entries_i[i][ASID_W-1:0] == key_i[ASID_W-1:0];
      if (GLOBAL_EN) begin : g_glob
         assign any_asid = entries_i[i][GLOBAL_BIT];
      end else begin : g_noglob
         assign any_asid = 1'b0;
      end
      assign hit_o[i] = entries_i[i][VALID_BIT] && tag_eq && (asid_eq || any_asid);
   end
endmodule

// File: rtl/tlbe_pick.sv
module tlbe_pick #(
   parameter int unsigned N = 4,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] req_i,
   output logic         any_o,
   output logic [W-1:0] first_o,
   output logic         multi_o
);
   if (N < 2) begin : g_bad_n
      $error("tlbe_pick: N must be at least 2");
   end

   always_comb begin
      first_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) first_o = W'(i);
      end
   end

   assign any_o   = |req_i;
   assign multi_o = $countones(req_i) > 1;
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
   import tlbe_pkg::*;
#(
   parameter int unsigned SETS       = 16,
   parameter int unsigned WAYS       = 4,
   parameter int unsigned SP_ENTRIES = 16,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned SP_SHIFT   = 21,
   parameter int unsigned SP_BASE    = 2048,
   parameter bit          GLOBAL_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [31:0] wr_data,
   output logic [31:0] pd0_o,
   output logic [31:0] pd1_o,
   output logic [31:0] index_o,
   output logic        busy_o,
   output logic        utlb_inv_o
);
   localparam int unsigned ENTRIES = SETS * WAYS;
   localparam int unsigned SET_W   = $clog2(SETS);
   localparam int unsigned WAY_W   = $clog2(WAYS);
   localparam int unsigned ENT_W   = $clog2(ENTRIES);
   localparam int unsigned SP_W    = $clog2(SP_ENTRIES);
   localparam int unsigned IDX_W   = $clog2(SP_BASE + SP_ENTRIES);

   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("tlb_cmd_engine: SETS must be a power of two >= 2");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("tlb_cmd_engine: WAYS must be >= 2");
   end
   if (ENTRIES > SP_BASE) begin : g_bad_base
      $error("tlb_cmd_engine: main array overlaps large-page bank");
   end
   if (IDX_W > 30 || SP_SHIFT <= PAGE_SHIFT) begin : g_bad_idx
      $error("tlb_cmd_engine: index or shift parameters out of range");
   end

   logic [31:0] pd0_q, pd1_q, index_q;
   logic        busy_q, uinv_q;
   tlbe_cmd_e   cmd_q;
   logic [ENTRIES-1:0][31:0]    main_pd0, main_pd1;
   logic [SP_ENTRIES-1:0][31:0] sp_pd0, sp_pd1;
   logic [WAY_W-1:0] m_vict;
   logic [SP_W-1:0]  s_vict;

   // set selection and the ways of that set
   logic [SET_W-1:0]         set_sel;
   logic [ENT_W-1:0]         set_base;
   logic [WAYS-1:0][31:0]    set_view;
   logic [WAYS-1:0]          m_hit, m_free;
   logic [SP_ENTRIES-1:0]    s_hit, s_free;

   assign set_sel  = pd0_q[PAGE_SHIFT +: SET_W];
   assign set_base = ENT_W'(set_sel) * ENT_W'(WAYS);

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_view[w] = main_pd0[set_base + ENT_W'(w)];
         m_free[w]   = ~set_view[w][VALID_BIT];
      end
      for (int i = 0; i < SP_ENTRIES; i++) s_free[i] = ~sp_pd0[i][VALID_BIT];
   end

   tlbe_match #(.N(WAYS), .TAG_LSB(PAGE_SHIFT), .GLOBAL_EN(GLOBAL_EN)) u_mmatch (
      .entries_i(set_view), .key_i(pd0_q), .hit_o(m_hit));
   tlbe_match #(.N(SP_ENTRIES), .TAG_LSB(SP_SHIFT), .GLOBAL_EN(GLOBAL_EN)) u_smatch (
      .entries_i(sp_pd0), .key_i(pd0_q), .hit_o(s_hit));

   logic m_hit_any, m_hit_multi, m_free_any, m_free_multi;
   logic s_hit_any, s_hit_multi, s_free_any, s_free_multi;
   logic [WAY_W-1:0] m_hit_first, m_free_first;
   logic [SP_W-1:0]  s_hit_first, s_free_first;

   tlbe_pick #(.N(WAYS)) u_mhit (.req_i(m_hit), .any_o(m_hit_any),
      .first_o(m_hit_first), .multi_o(m_hit_multi));
   tlbe_pick #(.N(WAYS)) u_mfree (.req_i(m_free), .any_o(m_free_any),
      .first_o(m_free_first), .multi_o(m_free_multi));
   tlbe_pick #(.N(SP_ENTRIES)) u_shit (.req_i(s_hit), .any_o(s_hit_any),
      .first_o(s_hit_first), .multi_o(s_hit_multi));
   tlbe_pick #(.N(SP_ENTRIES)) u_sfree (.req_i(s_free), .any_o(s_free_any),
      .first_o(s_free_first), .multi_o(s_free_multi));

   // slot choices
   logic             is_sp;
   logic [WAY_W-1:0] m_get_way, m_ins_way;
   logic [SP_W-1:0]  s_get_slot, s_ins_slot;
   logic [ENT_W-1:0] m_get_ent, m_ins_ent;
   logic [31:0]      probe_res, getidx_res;
   logic [31:0]      tgt;
   logic             tgt_main, tgt_sp;
   logic [ENT_W-1:0] tgt_m;
   logic [SP_W-1:0]  tgt_s;

   assign is_sp = pd0_q[SIZE_BIT];

   always_comb begin
      m_get_way  = m_free_any ? m_free_first : m_vict;
      m_ins_way  = m_hit_any ? m_hit_first : m_get_way;
      s_get_slot = s_free_any ? s_free_first : s_vict;
      s_ins_slot = s_hit_any ? s_hit_first : s_get_slot;
      m_get_ent  = set_base + ENT_W'(m_get_way);
      m_ins_ent  = set_base + ENT_W'(m_ins_way);

      probe_res = 32'd0;
      if (is_sp ? s_hit_multi : m_hit_multi) begin
         probe_res[MISS_BIT] = 1'b1;
         probe_res[DUP_BIT]  = 1'b1;
      end else if (is_sp ? s_hit_any : m_hit_any) begin
         probe_res = is_sp ? SP_BASE + 32'(s_hit_first) : 32'(set_base + ENT_W'(m_hit_first));
      end else begin
         probe_res[MISS_BIT] = 1'b1;
      end
      getidx_res = is_sp ? SP_BASE + 32'(s_get_slot) : 32'(m_get_ent);

      tgt      = 32'(index_q[IDX_W-1:0]);
      tgt_main = tgt < ENTRIES;
      tgt_sp   = (tgt >= SP_BASE) && (tgt < SP_BASE + SP_ENTRIES);
      tgt_m    = tgt[ENT_W-1:0];
      tgt_s    = SP_W'(tgt - SP_BASE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd0_q    <= '0;
         pd1_q    <= '0;
         index_q  <= '0;
         busy_q   <= 1'b0;
         uinv_q   <= 1'b0;
         cmd_q    <= CMD_NONE;
         main_pd0 <= '0;
         main_pd1 <= '0;
         sp_pd0   <= '0;
         sp_pd1   <= '0;
         m_vict   <= '0;
         s_vict   <= '0;
      end else if (!busy_q) begin
         uinv_q <= 1'b0;
         if (wr_en) begin
            case (tlbe_reg_e'(wr_addr))
               REG_PD0:   pd0_q   <= wr_data;
               REG_PD1:   pd1_q   <= wr_data;
               REG_INDEX: index_q <= 32'(wr_data[IDX_W-1:0]);
               default: begin
                  cmd_q  <= tlbe_cmd_e'(wr_data[3:0]);
                  busy_q <= 1'b1;
               end
            endcase
         end
      end else begin
         busy_q <= 1'b0;
         uinv_q <= cmd_q inside {CMD_WRITE, CMD_INSERT, CMD_DELETE, CMD_UINV};
         case (cmd_q)
            CMD_WRITE, CMD_WRITE_NI: begin
               if (tgt_main) begin
                  main_pd0[tgt_m] <= pd0_q;
                  main_pd1[tgt_m] <= pd1_q;
               end else if (tgt_sp) begin
                  sp_pd0[tgt_s] <= pd0_q;
                  sp_pd1[tgt_s] <= pd1_q;
               end
            end
            CMD_READ: begin
               if (tgt_main) begin
                  pd0_q <= main_pd0[tgt_m];
                  pd1_q <= main_pd1[tgt_m];
               end else if (tgt_sp) begin
                  pd0_q <= sp_pd0[tgt_s];
                  pd1_q <= sp_pd1[tgt_s];
               end
            end
            CMD_PROBE: index_q <= probe_res;
            CMD_GETIDX: begin
               index_q <= getidx_res;
               if (is_sp && !s_free_any) s_vict <= s_vict + 1'b1;
               if (!is_sp && !m_free_any)
                  m_vict <= (m_vict == WAY_W'(WAYS - 1)) ? '0 : m_vict + 1'b1;
            end
            CMD_INSERT: begin
               if (is_sp) begin
                  sp_pd0[s_ins_slot] <= pd0_q | (32'd1 << VALID_BIT);
                  sp_pd1[s_ins_slot] <= pd1_q;
                  if (!s_hit_any && !s_free_any) s_vict <= s_vict + 1'b1;
               end else begin
                  main_pd0[m_ins_ent] <= pd0_q | (32'd1 << VALID_BIT);
                  main_pd1[m_ins_ent] <= pd1_q;
                  if (!m_hit_any && !m_free_any)
                     m_vict <= (m_vict == WAY_W'(WAYS - 1)) ? '0 : m_vict + 1'b1;
               end
            end
            CMD_DELETE: begin
               if (is_sp) begin
                  for (int i = 0; i < SP_ENTRIES; i++)
                     if (s_hit[i]) sp_pd0[i][VALID_BIT] <= 1'b0;
               end else begin
                  for (int w = 0; w < WAYS; w++)
                     if (m_hit[w]) main_pd0[set_base + ENT_W'(w)][VALID_BIT] <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign pd0_o      = pd0_q;
   assign pd1_o      = pd1_q;
   assign index_o    = index_q;
   assign busy_o     = busy_q;
   assign utlb_inv_o = uinv_q;

   // R12: a command occupies exactly one busy cycle
   p_busy_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);
   // R3: invalidate is a single-cycle pulse
   p_uinv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      uinv_q |=> !uinv_q);
   // R13: a pulse only follows an executing command
   p_uinv_after_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uinv_q) |-> $past(busy_q));
   // R12: index word holds unless written or a command runs
   p_index_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !(wr_en && wr_addr == REG_INDEX)) |=> $stable(index_q));
   // R6: duplicate code always carries the miss flag
   p_dup_has_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      index_q[DUP_BIT] |-> index_q[MISS_BIT]);
   // R12: descriptor word 0 changes only by write or by a read command
   p_pd0_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !(wr_en && wr_addr == REG_PD0)) |=> $stable(pd0_q));
endmodule

// File: tb/tlb_cmd_engine_tb_top.sv
module tlb_cmd_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;
   logic [31:0] pd0_o, pd1_o, index_o;
   logic        busy_o, utlb_inv_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] MISS = 32'h8000_0000;
   localparam logic [31:0] DUP  = 32'hC000_0000;

   always #5 clk = ~clk;

   tlb_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pd0_o(pd0_o), .pd1_o(pd1_o), .index_o(index_o), .busy_o(busy_o),
      .utlb_inv_o(utlb_inv_o));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // issues a command, returns the invalidate level in the result cycle
   task automatic cmd(input logic [3:0] c, output logic inv);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = {28'd0, c};
      @(negedge clk);
      wr_en = 1'b0;
      chk("R12 busy during command", {31'd0, busy_o}, 32'd1);
      @(negedge clk);
      inv = utlb_inv_o;
      chk("R12 busy cleared", {31'd0, busy_o}, 32'd0);
   endtask

   task automatic probe(input logic [31:0] key, input logic [31:0] exp, input string tag);
      logic inv;
      wreg(2'd0, key);
      cmd(4'd4, inv);
      chk(tag, index_o, exp);
      chk("R13 probe no pulse", {31'd0, inv}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 index after reset", index_o, 32'd0);
      chk("R1 busy after reset", {31'd0, busy_o}, 32'd0);
      chk("R1 pulse after reset", {31'd0, utlb_inv_o}, 32'd0);
      probe(32'h0002_5205, MISS, "R1 R5 empty array misses");
   endtask

   task automatic t_write_read;
      logic inv;
      wreg(2'd1, 32'h1234_5007);
      wreg(2'd2, 32'd22);
      wreg(2'd0, 32'h0002_5205);
      cmd(4'd1, inv);
      chk("R3 write pulses", {31'd0, inv}, 32'd1);
      @(negedge clk);
      chk("R3 pulse one cycle", {31'd0, utlb_inv_o}, 32'd0);
      probe(32'h0002_5205, 32'd22, "R4 hit set 5 way 2");
      probe(32'h0002_5206, MISS, "R7 other asid misses");
      wreg(2'd0, 32'd0);
      wreg(2'd1, 32'd0);
      wreg(2'd2, 32'd22);
      cmd(4'd3, inv);
      chk("R3 read word0", pd0_o, 32'h0002_5205);
      chk("R2 read word1", pd1_o, 32'h1234_5007);
      chk("R13 read no pulse", {31'd0, inv}, 32'd0);
   endtask

   task automatic t_write_quiet_global;
      logic inv;
      wreg(2'd0, 32'h0003_1307);
      wreg(2'd1, 32'hAAAA_0001);
      wreg(2'd2, 32'd4);
      cmd(4'd2, inv);
      chk("R3 quiet write no pulse", {31'd0, inv}, 32'd0);
      probe(32'h0003_1209, 32'd4, "R7 global matches any asid");
   endtask

   task automatic t_dup_delete;
      logic inv;
      wreg(2'd0, 32'h0002_5205);
      wreg(2'd1, 32'h0000_0001);
      wreg(2'd2, 32'd23);
      cmd(4'd1, inv);
      probe(32'h0002_5205, DUP, "R6 duplicate code");
      cmd(4'd7, inv);
      chk("R10 delete pulses", {31'd0, inv}, 32'd1);
      probe(32'h0002_5205, MISS, "R10 both copies removed");
   endtask

   task automatic t_getidx_insert;
      logic inv;
      wreg(2'd0, 32'h0004_5201);
      cmd(4'd5, inv);
      chk("R8 lowest free way set 5", index_o, 32'd20);
      chk("R13 getidx no pulse", {31'd0, inv}, 32'd0);
      for (int k = 0; k < 4; k++) begin
         wreg(2'd0, (32'(k * 16 + 7) << 12) | 32'h001);
         wreg(2'd1, 32'(k));
         cmd(4'd6, inv);
         chk("R9 insert pulses", {31'd0, inv}, 32'd1);
         probe((32'(k * 16 + 7) << 12) | 32'h001, 32'(28 + k), "R9 insert fills next free way");
      end
      wreg(2'd0, 32'h0004_7201);
      cmd(4'd5, inv);
      chk("R8 full set victim way 0", index_o, 32'd28);
      cmd(4'd5, inv);
      chk("R8 victim advances", index_o, 32'd29);
      wreg(2'd0, 32'h0001_7201);
      wreg(2'd1, 32'h0000_BEEF);
      cmd(4'd6, inv);
      probe(32'h0001_7201, 32'd29, "R9 insert overwrites hit");
      wreg(2'd2, 32'd29);
      cmd(4'd3, inv);
      chk("R9 overwritten word1", pd1_o, 32'h0000_BEEF);
   endtask

   task automatic t_super;
      logic inv;
      wreg(2'd1, 32'h0000_0005);
      wreg(2'd0, 32'h0040_0603);
      cmd(4'd6, inv);
      probe(32'h0050_0603, 32'h800, "R11 large bank hit");
      probe(32'h0040_0203, MISS, "R11 no size bit uses main array");
      wreg(2'd0, 32'h0040_0603);
      cmd(4'd5, inv);
      chk("R11 large bank free slot", index_o, 32'h801);
      wreg(2'd2, 32'h800);
      cmd(4'd3, inv);
      chk("R11 read large bank word0", pd0_o, 32'h0040_0603);
      chk("R11 read large bank word1", pd1_o, 32'h0000_0005);
      cmd(4'd7, inv);
      probe(32'h0040_0603, MISS, "R11 large bank delete");
   endtask

   task automatic t_inv_busy;
      logic inv;
      cmd(4'd8, inv);
      chk("R13 invalidate command pulses", {31'd0, inv}, 32'd1);
      wreg(2'd0, 32'h0003_1209);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'd4;
      @(negedge clk);
      wr_addr = 2'd2; wr_data = 32'h55;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R12 index write while busy ignored", index_o, 32'd4);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'd4;
      @(negedge clk);
      wr_data = 32'd8;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R12 command while busy ignored", {31'd0, utlb_inv_o}, 32'd0);
      chk("R12 no second command", {31'd0, busy_o}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_write_quiet_global();
      t_dup_delete();
      t_getidx_insert();
      t_super();
      t_inv_busy();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule